// File: doc/BRIEF.md
# Control-Flow Pointer Check Unit

This execution unit carries out one checked-branch instruction used for control-flow integrity. It receives a 64-bit pointer operand, the PC of the instruction and the decoded immediates. It decides whether the pointer is a legal indirect target. A pointer is legal when it is aligned to a power of two and lies inside a window. The window begins at a PC-relative offset, and its length is the size immediate multiplied by the alignment.

A legal pointer lets execution fall through. An illegal pointer causes one of two outcomes. If the handler offset is zero, the unit raises a trap. Otherwise it sends control to a slow-path handler at a PC-relative address. A build-time option gives a compact variant with no handler offset; that variant traps on every failure.

Requests enter through a valid/ready handshake. The verdict appears one clock later in an output register, which holds it until the consumer takes it.

Top module: `cfi_check_unit`

## Requirements
- R1: A request accepted on a clock edge (in_valid and in_ready both high) produces out_valid high after that edge, with the verdict for that request.
- R2: While out_valid is high and out_ready is low, in_ready is low, and the verdict and redirect_pc are held unchanged.
- R3: With exponent e (4 bits), a pointer whose low e bits are not all zero fails. For e = 0 there is no alignment constraint.
- R4: The window start is PC plus the base offset. The base offset is a 28-bit two's-complement value, sign-extended to 64 bits. A pointer below the start fails.
- R5: The window end is start + (size << e), and the end is exclusive. A pointer at or above the end fails. The last aligned slot below the end passes.
- R6: A size of zero makes every pointer fail.
- R7: The window end is computed with a 65th carry bit. A window that reaches the top of the address space therefore still accepts pointers near the top.
- R8: When a check fails and the 28-bit handler offset is zero, out_trap is raised.
- R9: When a check fails and the handler offset is nonzero, out_redirect_valid is raised. out_redirect_pc is PC plus the sign-extended handler offset.
- R10: When out_valid is high, exactly one of out_pass, out_trap and out_redirect_valid is high. When out_valid is low, all three are low.
- R11: With parameter COMPACT = 1, the handler offset is ignored and every failure traps.
- R12: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_ptr | input | 64 | Pointer under test |
| in_pc | input | 64 | PC of the check instruction |
| in_exp | input | 4 | Alignment exponent |
| in_size | input | 20 | Window length in aligned units |
| in_base_off | input | 28 | Signed PC-relative window start |
| in_fail_off | input | 28 | Signed PC-relative handler offset, 0 means trap |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Consumer takes the verdict |
| out_pass | output | 1 | Check passed, fall through |
| out_trap | output | 1 | Check failed, trap |
| out_redirect_valid | output | 1 | Check failed, branch to handler |
| out_redirect_pc | output | 64 | Handler address |

## Verification
The hardest case to reach is a window that runs past the top of the 64-bit address space. A sum truncated to 64 bits would wrap to a small end value and wrongly reject pointers near the top. The stimulus places the PC just below the top, uses a positive base offset and a span large enough to overflow, and then tests a pointer inside the window near the top. Negative offsets come from PCs just above a power-of-two boundary. Back-pressure is tested by holding out_ready low while a second request waits at the input.

// File: rtl/cfi_pkg.sv
package cfi_pkg;
    typedef enum logic [1:0] {
        VERDICT_PASS  = 2'd0,
        VERDICT_TRAP  = 2'd1,
        VERDICT_REDIR = 2'd2
    } cfi_verdict_t;

    typedef struct packed {
        logic valid;
        logic pass;
        logic trap;
        logic redir;
    } cfi_flags_t;
endpackage

// File: rtl/cfi_align_chk.sv
module cfi_align_chk #(
    parameter int ADDR_W = 64,
    parameter int EXP_W  = 4
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [EXP_W-1:0]  exp_sel,
    output logic              misaligned
);
    logic [ADDR_W-1:0] low_mask;

    always_comb begin
        low_mask   = (ADDR_W'(1) << exp_sel) - ADDR_W'(1);
        misaligned = |(ptr & low_mask);
    end
endmodule

// File: rtl/cfi_range_chk.sv
module cfi_range_chk #(
    parameter int ADDR_W = 64,
    parameter int EXP_W  = 4,
    parameter int SIZE_W = 20,
    parameter int OFF_W  = 28
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFF_W-1:0]  base_off,
    input  logic [SIZE_W-1:0] size,
    input  logic [EXP_W-1:0]  exp_sel,
    output logic              out_of_range
);
    localparam int WIDE_W = ADDR_W + 1;

    logic [ADDR_W-1:0] win_lo;
    logic [WIDE_W-1:0] span;
    logic [WIDE_W-1:0] win_hi;
    logic              below, above;

    always_comb begin
        win_lo       = pc + {{(ADDR_W-OFF_W){base_off[OFF_W-1]}}, base_off};
        span         = WIDE_W'(size) << exp_sel;
        win_hi       = {1'b0, win_lo} + span;
        below        = ptr < win_lo;
        above        = {1'b0, ptr} >= win_hi;
        out_of_range = below || above;
    end
endmodule

// File: rtl/cfi_target_gen.sv
module cfi_target_gen #(
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 28
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFF_W-1:0]  fail_off,
    output logic              has_target,
    output logic [ADDR_W-1:0] target
);
    always_comb begin
        has_target = |fail_off;
        target     = pc + {{(ADDR_W-OFF_W){fail_off[OFF_W-1]}}, fail_off};
    end
endmodule

// File: rtl/cfi_check_unit.sv
module cfi_check_unit
    import cfi_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int EXP_W   = 4,
    parameter int SIZE_W  = 20,
    parameter int OFF_W   = 28,
    parameter bit COMPACT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_ptr,
    input  logic [ADDR_W-1:0] in_pc,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [SIZE_W-1:0] in_size,
    input  logic [OFF_W-1:0]  in_base_off,
    input  logic [OFF_W-1:0]  in_fail_off,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_pass,
    output logic              out_trap,
    output logic              out_redirect_valid,
    output logic [ADDR_W-1:0] out_redirect_pc
);
    logic              misaligned, out_of_range, has_target;
    logic [ADDR_W-1:0] target;
    cfi_verdict_t      verdict;
    cfi_flags_t        flags_d, flags_q;
    logic [ADDR_W-1:0] rpc_d, rpc_q;
    logic              accept;

    cfi_align_chk #(.ADDR_W(ADDR_W), .EXP_W(EXP_W)) u_align (
        .ptr(in_ptr), .exp_sel(in_exp), .misaligned(misaligned)
    );

    cfi_range_chk #(.ADDR_W(ADDR_W), .EXP_W(EXP_W), .SIZE_W(SIZE_W), .OFF_W(OFF_W)) u_range (
        .ptr(in_ptr), .pc(in_pc), .base_off(in_base_off), .size(in_size),
        .exp_sel(in_exp), .out_of_range(out_of_range)
    );

    generate
        if (COMPACT) begin : g_compact
            assign has_target = 1'b0;
            assign target     = '0;
        end else begin : g_full
            cfi_target_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_target (
                .pc(in_pc), .fail_off(in_fail_off),
                .has_target(has_target), .target(target)
            );
        end
    endgenerate

    assign in_ready = !flags_q.valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        if (!(misaligned || out_of_range)) verdict = VERDICT_PASS;
        else if (has_target)               verdict = VERDICT_REDIR;
        else                               verdict = VERDICT_TRAP;

        flags_d = flags_q;
        rpc_d   = rpc_q;
        if (accept) begin
            flags_d.valid = 1'b1;
            flags_d.pass  = (verdict == VERDICT_PASS);
            flags_d.trap  = (verdict == VERDICT_TRAP);
            flags_d.redir = (verdict == VERDICT_REDIR);
            rpc_d         = (verdict == VERDICT_REDIR) ? target : '0;
        end else if (flags_q.valid && out_ready) begin
            flags_d = '0;
            rpc_d   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            rpc_q   <= '0;
        end else begin
            flags_q <= flags_d;
            rpc_q   <= rpc_d;
        end
    end

    assign out_valid          = flags_q.valid;
    assign out_pass           = flags_q.pass;
    assign out_trap           = flags_q.trap;
    assign out_redirect_valid = flags_q.redir;
    assign out_redirect_pc    = rpc_q;

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pass) && $stable(out_trap)
                                       && $stable(out_redirect_valid) && $stable(out_redirect_pc)));

    p_one_verdict_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones({out_pass, out_trap, out_redirect_valid}) == 1));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_pass || out_trap || out_redirect_valid));

    p_no_redirect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (COMPACT && out_valid) |-> !out_redirect_valid);
endmodule

// File: tb/tb_cfi_check_unit.sv
module tb_cfi_check_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready, in_ready_c;
    logic [63:0] in_ptr = '0, in_pc = '0;
    logic [3:0]  in_exp = '0;
    logic [19:0] in_size = '0;
    logic [27:0] in_base_off = '0, in_fail_off = '0;
    logic        out_ready = 1'b1;
    logic        out_valid, out_pass, out_trap, out_redir;
    logic [63:0] out_rpc;
    logic        c_valid, c_pass, c_trap, c_redir;
    logic [63:0] c_rpc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cfi_check_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_ptr(in_ptr), .in_pc(in_pc), .in_exp(in_exp), .in_size(in_size),
        .in_base_off(in_base_off), .in_fail_off(in_fail_off),
        .out_valid(out_valid), .out_ready(out_ready), .out_pass(out_pass),
        .out_trap(out_trap), .out_redirect_valid(out_redir), .out_redirect_pc(out_rpc)
    );

    cfi_check_unit #(.COMPACT(1'b1)) dut_c (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_c),
        .in_ptr(in_ptr), .in_pc(in_pc), .in_exp(in_exp), .in_size(in_size),
        .in_base_off(in_base_off), .in_fail_off(in_fail_off),
        .out_valid(c_valid), .out_ready(out_ready), .out_pass(c_pass),
        .out_trap(c_trap), .out_redirect_valid(c_redir), .out_redirect_pc(c_rpc)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    // verdict code: 0 pass, 1 trap, 2 redirect
    task automatic run_req(string req, logic [63:0] pc, logic [63:0] ptr, logic [3:0] e,
                           logic [19:0] sz, logic [27:0] boff, logic [27:0] foff,
                           int verdict, logic [63:0] exp_rpc);
        @(negedge clk);
        in_pc = pc; in_ptr = ptr; in_exp = e; in_size = sz;
        in_base_off = boff; in_fail_off = foff; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid"}, 64'(out_valid), 64'd1);
        chk({req, " pass"},  64'(out_pass),  64'(verdict == 0));
        chk({req, " trap"},  64'(out_trap),  64'(verdict == 1));
        chk({req, " redir"}, 64'(out_redir), 64'(verdict == 2));
        if (verdict == 2) chk({req, " target"}, out_rpc, exp_rpc);
    endtask

    task automatic t_reset();
        chk("R12 out_valid", 64'(out_valid), 64'd0);
        chk("R12 in_ready",  64'(in_ready),  64'd1);
        chk("R10 idle flags", 64'({out_pass, out_trap, out_redir}), 64'd0);
    endtask

    task automatic t_window();
        // start 0x1000_0100, e=3, size 16 -> end 0x1000_0180
        run_req("R1 R5 inside", 64'h1000_0000, 64'h1000_0140, 4'd3, 20'd16, 28'h100, 28'h0, 0, '0);
        run_req("R5 last slot", 64'h1000_0000, 64'h1000_0178, 4'd3, 20'd16, 28'h100, 28'h0, 0, '0);
        run_req("R5 R8 at end", 64'h1000_0000, 64'h1000_0180, 4'd3, 20'd16, 28'h100, 28'h0, 1, '0);
        run_req("R4 below",     64'h1000_0000, 64'h1000_00F8, 4'd3, 20'd16, 28'h100, 28'h0, 1, '0);
        run_req("R4 at start",  64'h1000_0000, 64'h1000_0100, 4'd3, 20'd16, 28'h100, 28'h0, 0, '0);
    endtask

    task automatic t_align();
        run_req("R3 R9 misaligned", 64'h1000_0000, 64'h1000_0144, 4'd3, 20'd16, 28'h100, 28'h40,
                2, 64'h1000_0040);
        chk("R11 compact trap",  64'(c_trap),  64'd1);
        chk("R11 compact redir", 64'(c_redir), 64'd0);
        run_req("R3 exp zero", 64'h1000_0000, 64'h1000_0101, 4'd0, 20'd16, 28'h100, 28'h40, 0, '0);
        run_req("R3 exp max", 64'h0, 64'h8000, 4'd15, 20'd2, 28'h0, 28'h0, 0, '0);
        run_req("R3 exp max off", 64'h0, 64'h8008, 4'd15, 20'd2, 28'h0, 28'h0, 1, '0);
    endtask

    task automatic t_negative();
        // start 0x0FFF_FF00, e=3, size 4 -> end 0x0FFF_FF20
        run_req("R4 neg base", 64'h1000_0000, 64'h0FFF_FF00, 4'd3, 20'd4, 28'hFFF_FF00, 28'h0, 0, '0);
        run_req("R9 neg target", 64'h1000_0000, 64'h0FFF_FF20, 4'd3, 20'd4, 28'hFFF_FF00,
                28'hFFF_FFF0, 2, 64'h0FFF_FFF0);
    endtask

    task automatic t_zero_size();
        run_req("R6 zero size", 64'h1000_0000, 64'h1000_0100, 4'd0, 20'd0, 28'h100, 28'h0, 1, '0);
    endtask

    task automatic t_top_wrap();
        // start 0xFFFF_FFFF_FFFF_F800, span 0x1000 runs past 2^64
        run_req("R7 near top", 64'hFFFF_FFFF_FFFF_F000, 64'hFFFF_FFFF_FFFF_FF00, 4'd4, 20'h100,
                28'h800, 28'h0, 0, '0);
        run_req("R7 low ptr", 64'hFFFF_FFFF_FFFF_F000, 64'h0000_0000_0000_0100, 4'd4, 20'h100,
                28'h800, 28'h0, 1, '0);
    endtask

    task automatic t_backpressure();
        @(negedge clk);
        out_ready = 1'b0;
        in_pc = 64'h1000_0000; in_ptr = 64'h1000_0140; in_exp = 4'd3; in_size = 20'd16;
        in_base_off = 28'h100; in_fail_off = 28'h0; in_valid = 1'b1;
        @(negedge clk);
        // second request (fails -> trap) waits while stalled
        in_ptr = 64'h1000_0180;
        chk("R2 held pass", 64'(out_pass), 64'd1);
        chk("R2 in_ready low", 64'(in_ready), 64'd0);
        @(negedge clk);
        chk("R2 still pass", 64'(out_pass), 64'd1);
        chk("R2 still valid", 64'(out_valid), 64'd1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 second verdict", 64'(out_trap), 64'd1);
        @(negedge clk);
        chk("R10 drained valid", 64'(out_valid), 64'd0);
        chk("R10 drained flags", 64'({out_pass, out_trap, out_redir}), 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_window();
        t_align();
        t_negative();
        t_zero_size();
        t_top_wrap();
        t_backpressure();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule